// File: doc/BRIEF.md
# Bank-switched high memory controller

This block steers the top 12 KB of a 16-bit address space, D000 to FFFF, between system ROM and a RAM overlay. The overlay has two separate 4 KB banks that share the D000 window and one 8 KB region behind E000. Each of these RAM areas exists twice, once in main and once in auxiliary memory. The block holds three control bits: which D000 bank is active, whether reads go to RAM, and whether writes go to RAM. It also answers two status reads. The memory arrays themselves live outside the block.

Software changes the control bits without a data transfer. Any read or write in the sixteen-address window C080 to C08F loads all three bits from address bits 3, 2 and 1. For each strobed access the block gives one-hot read and write selects. An external alternate-zero-page flag picks the main or auxiliary copy of the RAM.

Top module: `lcbank_top`

## Requirements
- R1: After reset the D000 bank 2 is active, reads go to ROM and writes are dropped. A read of C011 returns 0x80, and a read of C012 returns 0x00.
- R2: A read- or write-strobed access with address[15:4] = 0xC08 loads the bank bit at the next clock edge. Address bit 3 = 1 selects bank 1, and 0 selects bank 2.
- R3: The same access sets the write-RAM flag to address bit 2.
- R4: The same access sets the read-RAM flag to address bit 1 XOR address bit 2.
- R5: A strobed read of C011 raises stat_hit_o and returns 0x80 when bank 2 is active. A strobed read of C012 raises stat_hit_o and returns 0x80 when read-RAM is set. Otherwise both reads return 0x00. For any other access stat_hit_o and stat_data_o are 0.
- R6: The source index is carried in rd_sel_o and wr_sel_o as a one-hot bit, with these codes: 0 = ROM, 1 = bank 1 main, 2 = bank 2 main, 3 = E000 main, 4 = bank 1 aux, 5 = bank 2 aux, 6 = E000 aux. A read in D000–DFFF selects ROM (bit 0) when read-RAM is clear. When read-RAM is set it selects the active bank, using bit 1 or 2 with altzp_i low and bit 4 or 5 with altzp_i high.
- R7: A read in E000–FFFF selects ROM when read-RAM is clear. When read-RAM is set it selects bit 3, or bit 6 with altzp_i high.
- R8: A write in D000–FFFF selects the RAM bit that R6 and R7 give for a RAM read, but only while write-RAM is set. Otherwise wr_sel_o is 0. ROM (bit 0) is never a write target.
- R9: An access to C08x is routed with the control state that existed before that access. An address in C08x with no strobe leaves the state unchanged.
- R10: At most one bit of rd_sel_o and at most one bit of wr_sel_o is set. All selects are 0 without the matching strobe or outside D000–FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 16 | access address |
| rd_i | input | 1 | read strobe |
| wr_i | input | 1 | write strobe |
| altzp_i | input | 1 | selects auxiliary RAM copies when high |
| rd_sel_o | output | 7 | one-hot read source select |
| wr_sel_o | output | 7 | one-hot write target select |
| stat_hit_o | output | 1 | status read decoded this cycle |
| stat_data_o | output | 8 | status byte |

## Verification
The bound checker checks, on every cycle, several properties of the control state and the selects. It checks that each control access loads the bank, write and read flags from the address bits of that access, and that the state holds otherwise. It checks that the selects stay one-hot or zero, that a clear write flag drops writes, that a clear read flag routes the high region to ROM, and that the C012 status bit follows the read flag. Some behaviour needs the bench's full sweep to show: every one of the sixteen control addresses, with both strobe kinds, followed by routing in both regions with both main and auxiliary copies. Only that sweep confirms that the exact select index and bank choice are right, and that a strobeless control address is ignored.

// File: rtl/lcbank_pkg.sv
package lcbank_pkg;
  localparam int unsigned SRC_N = 7;

  typedef enum logic [2:0] {
    SRC_ROM     = 3'd0,
    SRC_D1_MAIN = 3'd1,
    SRC_D2_MAIN = 3'd2,
    SRC_E_MAIN  = 3'd3,
    SRC_D1_AUX  = 3'd4,
    SRC_D2_AUX  = 3'd5,
    SRC_E_AUX   = 3'd6
  } src_e;

  typedef struct packed {
    logic bank2;
    logic rd_ram;
    logic wr_ram;
  } lc_state_t;

  localparam lc_state_t STATE_RST = '{bank2: 1'b1, rd_ram: 1'b0, wr_ram: 1'b0};
endpackage

// File: rtl/lcbank_ctl.sv
module lcbank_ctl
  import lcbank_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 16,
  parameter logic [ADDR_W-5:0] CTL_PAGE = 12'hC08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output lc_state_t         state_o
);
  logic      ctl_hit;
  lc_state_t state_d, state_q;

  assign ctl_hit = (rd_i | wr_i) && (addr_i[ADDR_W-1:4] == CTL_PAGE);

  always_comb begin
    state_d = state_q;
    if (ctl_hit) begin
      state_d.bank2  = ~addr_i[3];
      state_d.wr_ram = addr_i[2];
      // read flag sense flips with the write bit
      state_d.rd_ram = addr_i[1] ^ addr_i[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= STATE_RST;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lcbank_route.sv
module lcbank_route
  import lcbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [3:0]  D_NIB  = 4'hD
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           rd_i,
  input  logic                           wr_i,
  input  logic                           altzp_i,
  input  lc_state_t                      state_i,
  output logic              [SRC_N-1:0]  rd_sel_o,
  output logic              [SRC_N-1:0]  wr_sel_o
);
  localparam logic [2:0] E_TOP = 3'b111;

  logic in_d, in_e, in_hi;
  logic rd_hit, wr_hit;
  src_e ram_src, rd_src;

  assign in_d  = addr_i[ADDR_W-1 -: 4] == D_NIB;
  assign in_e  = addr_i[ADDR_W-1 -: 3] == E_TOP;
  assign in_hi = in_d | in_e;

  always_comb begin
    if (in_d) begin
      if (altzp_i) ram_src = state_i.bank2 ? SRC_D2_AUX  : SRC_D1_AUX;
      else         ram_src = state_i.bank2 ? SRC_D2_MAIN : SRC_D1_MAIN;
    end else begin
      ram_src = altzp_i ? SRC_E_AUX : SRC_E_MAIN;
    end
  end

  assign rd_src = state_i.rd_ram ? ram_src : SRC_ROM;
  assign rd_hit = rd_i & in_hi;
  assign wr_hit = wr_i & in_hi & state_i.wr_ram;

  for (genvar g = 0; g < SRC_N; g++) begin : g_sel
    assign rd_sel_o[g] = rd_hit && (rd_src == src_e'(3'(g)));
    assign wr_sel_o[g] = wr_hit && (ram_src == src_e'(3'(g)));
  end
endmodule

// File: rtl/lcbank_status.sv
module lcbank_status
  import lcbank_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 16,
  parameter int unsigned       DATA_W         = 8,
  parameter int unsigned       FLAG_BIT       = 7,
  parameter logic [ADDR_W-1:0] STAT_BANK_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] STAT_RAM_ADDR  = 16'hC012
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  lc_state_t         state_i,
  output logic              stat_hit_o,
  output logic [DATA_W-1:0] stat_data_o
);
  always_comb begin
    stat_hit_o  = 1'b0;
    stat_data_o = '0;
    if (rd_i && addr_i == STAT_BANK_ADDR) begin
      stat_hit_o            = 1'b1;
      stat_data_o[FLAG_BIT] = state_i.bank2;
    end else if (rd_i && addr_i == STAT_RAM_ADDR) begin
      stat_hit_o            = 1'b1;
      stat_data_o[FLAG_BIT] = state_i.rd_ram;
    end
  end
endmodule

// File: rtl/lcbank_top.sv
module lcbank_top
  import lcbank_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 16,
  parameter int unsigned       DATA_W         = 8,
  parameter logic [ADDR_W-5:0] CTL_PAGE       = 12'hC08,
  parameter logic [ADDR_W-1:0] STAT_BANK_ADDR = 16'hC011,
  parameter logic [ADDR_W-1:0] STAT_RAM_ADDR  = 16'hC012
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              altzp_i,
  output logic [SRC_N-1:0]  rd_sel_o,
  output logic [SRC_N-1:0]  wr_sel_o,
  output logic              stat_hit_o,
  output logic [DATA_W-1:0] stat_data_o
);
  lc_state_t state_q;

  lcbank_ctl #(.ADDR_W(ADDR_W), .CTL_PAGE(CTL_PAGE)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .state_o (state_q)
  );

  lcbank_route #(.ADDR_W(ADDR_W)) u_route (
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .altzp_i  (altzp_i),
    .state_i  (state_q),
    .rd_sel_o (rd_sel_o),
    .wr_sel_o (wr_sel_o)
  );

  lcbank_status #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_BIT(DATA_W-1),
    .STAT_BANK_ADDR(STAT_BANK_ADDR), .STAT_RAM_ADDR(STAT_RAM_ADDR)
  ) u_status (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .state_i     (state_q),
    .stat_hit_o  (stat_hit_o),
    .stat_data_o (stat_data_o)
  );
endmodule

// File: rtl/lcbank_chk.sv
module lcbank_chk
  import lcbank_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter int unsigned       DATA_W        = 8,
  parameter logic [ADDR_W-5:0] CTL_PAGE      = 12'hC08,
  parameter logic [ADDR_W-1:0] STAT_RAM_ADDR = 16'hC012
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [SRC_N-1:0]  rd_sel_i,
  input logic [SRC_N-1:0]  wr_sel_i,
  input logic [DATA_W-1:0] stat_data_i,
  input lc_state_t         state_i
);
  logic ctl_acc, in_hi;
  assign ctl_acc = (rd_i | wr_i) && (addr_i[ADDR_W-1:4] == CTL_PAGE);
  assign in_hi   = addr_i[ADDR_W-1 -: 4] >= 4'hD;

  assert_rd_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel_i));
  assert_wr_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_i));
  assert_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i | wr_i) |-> (rd_sel_i == '0 && wr_sel_i == '0));
  assert_bank_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_acc |=> state_i.bank2 == !$past(addr_i[3]));
  assert_wr_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_acc |=> state_i.wr_ram == $past(addr_i[2]));
  assert_rd_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_acc |=> state_i.rd_ram == ($past(addr_i[1]) ^ $past(addr_i[2])));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_acc |=> $stable(state_i));
  assert_stat_ram_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == STAT_RAM_ADDR) |-> stat_data_i[DATA_W-1] == state_i.rd_ram);
  assert_rom_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_hi && !state_i.rd_ram) |-> rd_sel_i == SRC_N'(1));
  assert_wr_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !state_i.wr_ram) |-> wr_sel_i == '0);
endmodule

bind lcbank_top lcbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_PAGE(CTL_PAGE), .STAT_RAM_ADDR(STAT_RAM_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .rd_sel_i    (rd_sel_o),
  .wr_sel_i    (wr_sel_o),
  .stat_data_i (stat_data_o),
  .state_i     (state_q)
);

// File: tb/lcbank_top_bench.sv
module lcbank_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, alt = 1'b0;
  logic [6:0]  rd_sel, wr_sel;
  logic        stat_hit;
  logic [7:0]  stat_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic m_bank2 = 1'b1, m_rd = 1'b0, m_wr = 1'b0;

  always #5 clk = ~clk;

  lcbank_top u_lcbank_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr), .altzp_i(alt),
    .rd_sel_o(rd_sel), .wr_sel_o(wr_sel), .stat_hit_o(stat_hit), .stat_data_o(stat_data)
  );

  function automatic int ram_idx(logic [15:0] a, logic al);
    if (a < 16'hE000) return (m_bank2 ? 2 : 1) + (al ? 3 : 0);
    return 3 + (al ? 3 : 0);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic access(logic [15:0] a, logic r, logic w, logic al, string tag);
    int e_rd, e_wr, e_hit, e_dat;
    @(negedge clk);
    addr = a; rd = r; wr = w; alt = al;
    #4;
    e_rd = 0; e_wr = 0; e_hit = 0; e_dat = 0;
    if (r && a >= 16'hD000) e_rd = m_rd ? (1 << ram_idx(a, al)) : 1;
    if (w && a >= 16'hD000 && m_wr) e_wr = 1 << ram_idx(a, al);
    if (r && a == 16'hC011) begin e_hit = 1; e_dat = m_bank2 ? 8'h80 : 0; end
    if (r && a == 16'hC012) begin e_hit = 1; e_dat = m_rd ? 8'h80 : 0; end
    chk(tag, "rd_sel", int'(rd_sel), e_rd);
    chk(tag, "wr_sel", int'(wr_sel), e_wr);
    chk(tag, "stat_hit", int'(stat_hit), e_hit);
    chk(tag, "stat_data", int'(stat_data), e_dat);
    if ((r | w) && a[15:4] == 12'hC08) begin
      m_bank2 = ~a[3];
      m_wr    = a[2];
      m_rd    = a[1] ^ a[2];
    end
  endtask

  task automatic probe_all();
    access(16'hC011, 1, 0, 0, "R2");
    access(16'hC012, 1, 0, 0, "R4");
    for (int al = 0; al < 2; al++) begin
      access(16'hD000, 1, 0, al[0], "R6");
      access(16'hDFFF, 1, 0, al[0], "R6");
      access(16'hE000, 1, 0, al[0], "R7");
      access(16'hFFFF, 1, 0, al[0], "R7");
      access(16'hD5A3, 0, 1, al[0], "R3");
      access(16'hF00F, 0, 1, al[0], "R8");
    end
    access(16'hCFFF, 1, 1, 1, "R10");
    access(16'hD800, 0, 0, 0, "R10");
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(16'hC011, 1, 0, 0, "R1");
    access(16'hC012, 1, 0, 0, "R1");
    access(16'hD000, 1, 0, 0, "R1");
    access(16'hE000, 0, 1, 0, "R1");
    access(16'hC013, 1, 0, 0, "R5");
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 16; k++) begin
        // R9: the control access itself sees the previous state
        access(16'hC080 | 16'(k), s == 0, s == 1, 0, "R9");
        probe_all();
        // R9: strobeless control address must not load
        access(16'hC080 | 16'(k ^ 15), 0, 0, 0, "R9");
        access(16'hC011, 1, 0, 0, "R9");
        access(16'hC012, 1, 0, 0, "R9");
        access(16'hD000, 1, 1, 1, "R9");
      end
    end
    // both strobes at once on the control window
    access(16'hC08B, 1, 1, 0, "R2");
    probe_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule